// File: doc/BRIEF.md
# Handshaked SPI Master Link Controller

This block sits on the controller side of a two-way serial link and is the SPI master of it. The far end is a processor that cannot slow the clock down. Two sideband lines from that processor set the pace instead. The acknowledge line (`ack_in`) must show a rising edge before the master moves on after a transfer. The request line (`cmd_in`) asks the master to turn the link around and fetch a command. In the normal direction the block drains a small internal queue. Each entry goes out as a two-byte packet: a channel byte, then a data byte.

When the far end raises its request line, the master sends a switch notice on a reserved channel. It then waits for an acknowledge and clocks in a fixed six-byte command frame, sending zeros on MOSI while it does so. On the next acknowledge it hands the frame to the local command logic as a one-cycle strobe. If the frame asks for a reply, the master waits for the local logic to offer a response and sends that response as an ordinary two-byte packet.

Every waiting state runs a timeout counter. If the far end goes silent, the counter expires and the controller recovers. It chooses its recovery state from the level of the acknowledge line.

Top module: `ec_link_master`

## Requirements
- R1: An upstream packet is one SPI mode-0 transaction of exactly 16 bits: the channel byte, then the data byte, each sent MSB first. Chip select stays low for the whole transaction and rises after the last bit. SCLK is low whenever chip select is high. Queue entries leave in the order they were pushed.
- R2: After any upstream packet the controller starts no new transaction until a rising edge on `ack_in`. That edge returns it to the upstream state, where the next queued entry is sent.
- R3: When reset is released, the controller enters the upstream state if `ack_in` is high and the off state if it is low. In the off state, queued entries are not sent. A rising edge on `ack_in` moves the controller from the off state to the upstream state.
- R4: In the upstream state, a rising edge on `cmd_in` sends the switch packet, channel 8'h04 with data 8'h00, and then waits for the acknowledge that releases the command pull. If the edge and a non-empty queue are seen in the same cycle, the switch packet goes first. A rising edge on `cmd_in` in any other state is ignored.
- R5: After the switch packet, a rising edge on `ack_in` starts one 48-bit transaction with MOSI held at 0. The received bytes are captured as the command frame, and `cmd_valid` is not yet raised.
- R6: In the pull-wait state, the next rising edge on `ack_in` raises `cmd_valid` for one cycle. At that point `cmd_frame` holds the six received bytes, with the first received byte in bits 47:40. Bits 43:40 of byte 1 are the command length and bits 35:32 are the response length. If the response length is 0, the controller returns to the upstream state.
- R7: If the response length is nonzero, the controller waits for `resp_valid` and then sends `{resp_chan, resp_data}` as one upstream packet, followed by the R2 wait. `resp_valid` in any other state is ignored.
- R8: If a waiting state sees no progress for `TIMEOUT_CYC` clock cycles, the controller moves to the upstream state when `ack_in` is high and to the off state when it is low.
- R9: The queue holds `QDEPTH` entries. A push while the queue is full is dropped. The drop sets `overflow`, which stays high until reset.
- R10: The SCLK period is `CLK_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_in | input | 1 | Acknowledge line from the slave (asynchronous) |
| cmd_in | input | 1 | Command request line from the slave (asynchronous) |
| push_valid | input | 1 | Queue an upstream entry this cycle |
| push_chan | input | 8 | Channel byte of the pushed entry |
| push_data | input | 8 | Data byte of the pushed entry |
| resp_valid | input | 1 | Response offered for the pending command |
| resp_chan | input | 8 | Channel byte of the response |
| resp_data | input | 8 | Data byte of the response |
| cmd_valid | output | 1 | One-cycle strobe: a command frame is delivered |
| cmd_frame | output | 48 | The six command bytes, first received in bits 47:40 |
| overflow | output | 1 | Sticky flag: a push was dropped |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the slave |
| spi_miso | input | 1 | SPI data from the slave |

## Verification
The bench builds the block with `QDEPTH` = 4, `CLK_DIV` = 4 and `TIMEOUT_CYC` = 200. With only four entries, the drop and the sticky flag can be reached in a few pushes while the link is held in its wait state. A short SCLK keeps the six-byte pull short. A 200-cycle timeout is long enough that acknowledges given on time never race it, and short enough that the bench can wait it out twice, once with acknowledge high and once with it low.

// File: rtl/ec_link_pkg.sv
package ec_link_pkg;

    localparam int BYTE_W    = 8;
    localparam int CMD_BYTES = 6;
    localparam int FRAME_W   = CMD_BYTES * BYTE_W;
    localparam int PKT_BITS  = 2 * BYTE_W;

    typedef enum logic [7:0] {
        CH_KBD    = 8'h01,
        CH_MOUSE  = 8'h02,
        CH_EVENT  = 8'h03,
        CH_SWITCH = 8'h04
    } chan_e;

    typedef struct packed {
        logic [BYTE_W-1:0] chan;
        logic [BYTE_W-1:0] data;
    } q_entry_t;

    typedef enum logic [3:0] {
        ST_CPUOFF,
        ST_UP,
        ST_TX_UP,
        ST_TX_SW,
        ST_WAIT,
        ST_SW_WAIT,
        ST_PULL,
        ST_PULL_WAIT,
        ST_RESP_WAIT,
        ST_TX_RESP
    } link_state_e;

    // Left-align a two-byte packet in the frame-wide shift register.
    function automatic logic [FRAME_W-1:0] pack_pkt(input logic [BYTE_W-1:0] chan,
                                                    input logic [BYTE_W-1:0] data);
        return {chan, data, {(FRAME_W-PKT_BITS){1'b0}}};
    endfunction

    // Response length: low nibble of command byte 1.
    function automatic logic [3:0] resp_len(input logic [FRAME_W-1:0] frame);
        return frame[FRAME_W-BYTE_W-5 -: 4];
    endfunction

endpackage

// File: rtl/link_sync_edge.sv
module link_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic level,
    output logic rise
);
    // No reset: the synchronizer keeps sampling during reset so that the
    // level is valid when reset is released.
    logic [STAGES-1:0] sr;
    logic              prev;

    always_ff @(posedge clk) begin
        sr   <= {sr[STAGES-2:0], din};
        prev <= sr[STAGES-1];
    end

    assign level = sr[STAGES-1];
    assign rise  = sr[STAGES-1] & ~prev;
endmodule

// File: rtl/link_queue.sv
module link_queue
    import ec_link_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  q_entry_t push_ent,
    input  logic     pop,
    output q_entry_t head,
    output logic     empty,
    output logic     overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    q_entry_t        mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic            full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && full) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/link_spi_shifter.sv
module link_spi_shifter #(
    parameter int CLK_DIV  = 8,
    parameter int MAX_BITS = 48,
    localparam int NBW     = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [NBW-1:0]      nbits,
    input  logic [MAX_BITS-1:0] tx,
    input  logic                miso,
    output logic                sclk,
    output logic                cs_n,
    output logic                mosi,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] rx
);
    localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
    localparam int DW   = $clog2(HALF + 1);

    logic [DW-1:0]       div;
    logic [NBW-1:0]      left;
    logic [MAX_BITS-1:0] tx_sr, rx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n  <= 1'b1;
            sclk  <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b0;
            div   <= '0;
            left  <= '0;
            tx_sr <= '0;
            rx_sr <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                cs_n  <= 1'b0;
                sclk  <= 1'b0;
                div   <= '0;
                left  <= nbits;
                tx_sr <= tx;
            end else if (busy) begin
                if (div == DW'(HALF - 1)) begin
                    div <= '0;
                    if (!sclk) begin
                        if (left == '0) begin
                            cs_n <= 1'b1;
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            sclk  <= 1'b1;
                            rx_sr <= {rx_sr[MAX_BITS-2:0], miso};
                        end
                    end else begin
                        sclk  <= 1'b0;
                        left  <= left - 1'b1;
                        tx_sr <= {tx_sr[MAX_BITS-2:0], 1'b0};
                    end
                end else begin
                    div <= div + 1'b1;
                end
            end
        end
    end

    assign mosi = busy & tx_sr[MAX_BITS-1];
    assign rx   = rx_sr;
endmodule

// File: rtl/ec_link_master.sv
module ec_link_master
    import ec_link_pkg::*;
#(
    parameter int QDEPTH      = 8,
    parameter int CLK_DIV     = 8,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ack_in,
    input  logic               cmd_in,
    input  logic               push_valid,
    input  logic [BYTE_W-1:0]  push_chan,
    input  logic [BYTE_W-1:0]  push_data,
    input  logic               resp_valid,
    input  logic [BYTE_W-1:0]  resp_chan,
    input  logic [BYTE_W-1:0]  resp_data,
    output logic               cmd_valid,
    output logic [FRAME_W-1:0] cmd_frame,
    output logic               overflow,
    output logic               spi_sclk,
    output logic               spi_cs_n,
    output logic               spi_mosi,
    input  logic               spi_miso
);
    localparam int NBW = $clog2(FRAME_W + 1);
    localparam int TW  = $clog2(TIMEOUT_CYC + 1);

    link_state_e        state, nxt;
    logic               ack_lvl, ack_rise, cmd_lvl, cmd_rise;
    q_entry_t           head, push_ent;
    logic               q_empty, pop;
    logic               sh_start, sh_busy, sh_done;
    logic [NBW-1:0]     sh_bits;
    logic [FRAME_W-1:0] sh_tx, sh_rx;
    logic [TW-1:0]      tmo_cnt;
    logic               waiting, tmo_hit, deliver;
    link_state_e        fallback;

    link_sync_edge #(.STAGES(2)) i_ack_sync (
        .clk(clk), .din(ack_in), .level(ack_lvl), .rise(ack_rise));

    link_sync_edge #(.STAGES(2)) i_cmd_sync (
        .clk(clk), .din(cmd_in), .level(cmd_lvl), .rise(cmd_rise));

    assign push_ent = '{chan: push_chan, data: push_data};

    link_queue #(.DEPTH(QDEPTH)) i_queue (
        .clk(clk), .rst(rst), .push(push_valid), .push_ent(push_ent),
        .pop(pop), .head(head), .empty(q_empty), .overflow(overflow));

    link_spi_shifter #(.CLK_DIV(CLK_DIV), .MAX_BITS(FRAME_W)) i_shift (
        .clk(clk), .rst(rst), .start(sh_start), .nbits(sh_bits), .tx(sh_tx),
        .miso(spi_miso), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .busy(sh_busy), .done(sh_done), .rx(sh_rx));

    assign waiting  = (state == ST_WAIT) || (state == ST_SW_WAIT) ||
                      (state == ST_PULL_WAIT) || (state == ST_RESP_WAIT);
    assign tmo_hit  = waiting && (tmo_cnt == TW'(TIMEOUT_CYC - 1));
    assign fallback = ack_lvl ? ST_UP : ST_CPUOFF;

    always_comb begin
        nxt      = state;
        sh_start = 1'b0;
        sh_bits  = NBW'(PKT_BITS);
        sh_tx    = pack_pkt(head.chan, head.data);
        pop      = 1'b0;
        deliver  = 1'b0;
        unique case (state)
            ST_CPUOFF: if (ack_rise) nxt = ST_UP;
            ST_UP: begin
                if (cmd_rise) begin
                    sh_start = 1'b1;
                    sh_tx    = pack_pkt(CH_SWITCH, 8'h00);
                    nxt      = ST_TX_SW;
                end else if (!q_empty) begin
                    sh_start = 1'b1;
                    pop      = 1'b1;
                    nxt      = ST_TX_UP;
                end
            end
            ST_TX_UP, ST_TX_RESP: if (sh_done) nxt = ST_WAIT;
            ST_TX_SW:             if (sh_done) nxt = ST_SW_WAIT;
            ST_PULL:              if (sh_done) nxt = ST_PULL_WAIT;
            ST_WAIT: begin
                if (ack_rise)     nxt = ST_UP;
                else if (tmo_hit) nxt = fallback;
            end
            ST_SW_WAIT: begin
                if (ack_rise) begin
                    sh_start = 1'b1;
                    sh_bits  = NBW'(FRAME_W);
                    sh_tx    = '0;
                    nxt      = ST_PULL;
                end else if (tmo_hit) begin
                    nxt = fallback;
                end
            end
            ST_PULL_WAIT: begin
                if (ack_rise) begin
                    deliver = 1'b1;
                    nxt     = (resp_len(cmd_frame) == 4'd0) ? ST_UP : ST_RESP_WAIT;
                end else if (tmo_hit) begin
                    nxt = fallback;
                end
            end
            ST_RESP_WAIT: begin
                if (resp_valid) begin
                    sh_start = 1'b1;
                    sh_tx    = pack_pkt(resp_chan, resp_data);
                    nxt      = ST_TX_RESP;
                end else if (tmo_hit) begin
                    nxt = fallback;
                end
            end
            default: nxt = fallback;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ack_lvl ? ST_UP : ST_CPUOFF;
            tmo_cnt   <= '0;
            cmd_valid <= 1'b0;
            cmd_frame <= '0;
        end else begin
            state     <= nxt;
            cmd_valid <= deliver;
            if (sh_start || !waiting) tmo_cnt <= '0;
            else                      tmo_cnt <= tmo_cnt + 1'b1;
            if (state == ST_PULL && sh_done) cmd_frame <= sh_rx;
        end
    end
endmodule

// File: rtl/ec_link_checker.sv
module ec_link_checker
    import ec_link_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        spi_cs_n,
    input logic        spi_sclk,
    input logic        cmd_valid,
    input logic        overflow,
    input link_state_e state,
    input logic        ack_rise,
    input logic        cmd_rise,
    input logic        tmo_hit
);
    assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    assert_wait_release_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && ack_rise) |=> (state == ST_UP));

    assert_cpuoff_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CPUOFF) |-> spi_cs_n);

    assert_cmd_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && cmd_rise && !ack_rise && !tmo_hit) |=> (state == ST_WAIT));

    assert_cmd_from_pull_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ($past(state) == ST_PULL_WAIT));

    assert_cmd_single_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    assert_timeout_fallback_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && tmo_hit && !ack_rise) |=> (state == ST_UP || state == ST_CPUOFF));

    assert_no_overflow_clear_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

bind ec_link_master ec_link_checker i_chk (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .cmd_valid(cmd_valid), .overflow(overflow), .state(state),
    .ack_rise(ack_rise), .cmd_rise(cmd_rise), .tmo_hit(tmo_hit));

// File: tb/test_ec_link_master.sv
module test_ec_link_master;
    localparam int QD  = 4;
    localparam int DIV = 4;
    localparam int TMO = 200;

    logic        clk = 1'b0, rst = 1'b1;
    logic        ack_in = 1'b0, cmd_in = 1'b0;
    logic        push_valid = 1'b0, resp_valid = 1'b0;
    logic [7:0]  push_chan = '0, push_data = '0, resp_chan = '0, resp_data = '0;
    logic        cmd_valid, overflow, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
    logic [47:0] cmd_frame;

    always #5 clk = ~clk;

    ec_link_master #(.QDEPTH(QD), .CLK_DIV(DIV), .TIMEOUT_CYC(TMO)) i_ec_link_master (
        .clk(clk), .rst(rst), .ack_in(ack_in), .cmd_in(cmd_in),
        .push_valid(push_valid), .push_chan(push_chan), .push_data(push_data),
        .resp_valid(resp_valid), .resp_chan(resp_chan), .resp_data(resp_data),
        .cmd_valid(cmd_valid), .cmd_frame(cmd_frame), .overflow(overflow),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso));

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Slave model, sampled on the falling system clock edge.
    logic [47:0] s_tx = '0, s_sh = '0, s_rx = '0, last_rx = '0, cv_frame = '0;
    int s_bits = 0, last_bits = 0, frames = 0, r_first = 0, last_period = 0, cv_cnt = 0;
    logic p_cs = 1'b1, p_sclk = 1'b0;
    assign spi_miso = s_sh[47];

    always @(negedge clk) begin
        if (p_cs && !spi_cs_n) begin
            s_sh <= s_tx; s_bits <= 0; s_rx <= '0;
        end
        if (!spi_cs_n && !p_sclk && spi_sclk) begin
            s_rx   <= {s_rx[46:0], spi_mosi};
            s_bits <= s_bits + 1;
            if (s_bits == 0) r_first <= cyc;
            if (s_bits == 1) last_period <= cyc - r_first;
        end
        if (p_sclk && !spi_sclk) s_sh <= {s_sh[46:0], 1'b0};
        if (!p_cs && spi_cs_n) begin
            frames <= frames + 1; last_bits <= s_bits; last_rx <= s_rx;
        end
        if (cmd_valid) begin
            cv_cnt <= cv_cnt + 1; cv_frame <= cmd_frame;
        end
        p_cs   <= spi_cs_n;
        p_sclk <= spi_sclk;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] c, input logic [7:0] d);
        @(negedge clk);
        push_valid = 1'b1; push_chan = c; push_data = d;
        @(negedge clk);
        push_valid = 1'b0;
        #1;
    endtask

    task automatic ack_pulse();
        @(negedge clk) ack_in = 1'b0;
        tick(3);
        @(negedge clk) ack_in = 1'b1;
        tick(4);
    endtask

    task automatic wait_frame(input string tag, input int start);
        bit got = 0;
        for (int i = 0; i < 800 && !got; i++) begin
            tick(1);
            if (frames != start) got = 1;
        end
        chk(got, tag, frames, start + 1);
    endtask

    task automatic expect_frame(input string tag, input logic [15:0] exp);
        int s = frames;
        wait_frame(tag, s);
        chk(last_bits == 16, {tag, " bits"}, last_bits, 16);
        chk(last_rx[15:0] == exp, {tag, " bytes"}, last_rx[15:0], exp);
    endtask

    task automatic expect_quiet(input string tag, input int n);
        int s = frames;
        tick(n);
        chk(frames == s, tag, frames, s);
    endtask

    task automatic t_reset_low();
        ack_in = 1'b0;
        rst = 1'b1;
        tick(6);
        @(negedge clk) rst = 1'b0;
        tick(1);
        chk(spi_cs_n == 1'b1, "R3 reset cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1 reset sclk", spi_sclk, 0);
        chk(cmd_valid == 1'b0, "R6 reset cmd_valid", cmd_valid, 0);
        chk(overflow == 1'b0, "R9 reset overflow", overflow, 0);
        push(8'h01, 8'hA5);
        expect_quiet("R3 off state holds queue", 60);
        @(negedge clk) ack_in = 1'b1;
        expect_frame("R3 R1 first packet", 16'h01A5);
        chk(last_period == DIV, "R10 sclk period", last_period, DIV);
        ack_pulse();
    endtask

    task automatic t_wait_gating();
        push(8'h02, 8'h11);
        expect_frame("R1 packet", 16'h0211);
        push(8'h03, 8'h22);
        expect_quiet("R2 gated in wait", 60);
        ack_pulse();
        expect_frame("R2 released packet", 16'h0322);
        ack_pulse();
    endtask

    task automatic t_cmd_ignored();
        push(8'h01, 8'h33);
        expect_frame("R1 packet", 16'h0133);
        @(negedge clk) cmd_in = 1'b1;
        expect_quiet("R4 cmd in wait", 40);
        ack_pulse();
        expect_quiet("R4 cmd edge not kept", 60);
        @(negedge clk) cmd_in = 1'b0;
        tick(4);
    endtask

    task automatic t_switch_pull();
        int cv0;
        int s;
        s_tx = 48'h5A20_DEAD_0000;
        cv0 = cv_cnt;
        @(negedge clk) cmd_in = 1'b1;
        push(8'h02, 8'h66);
        expect_frame("R4 switch first", 16'h0400);
        ack_pulse();
        s = frames;
        wait_frame("R5 pull frame", s);
        chk(last_bits == 48, "R5 pull length", last_bits, 48);
        chk(last_rx == 48'h0, "R5 zero mosi", last_rx, 0);
        chk(cv_cnt == cv0, "R5 no strobe yet", cv_cnt, cv0);
        ack_pulse();
        chk(cv_cnt == cv0 + 1, "R6 one strobe", cv_cnt, cv0 + 1);
        chk(cv_frame == 48'h5A20_DEAD_0000, "R6 frame", cv_frame, 48'h5A20_DEAD_0000);
        expect_frame("R6 back to upstream", 16'h0266);
        ack_pulse();
        @(negedge clk) cmd_in = 1'b0;
        tick(4);
    endtask

    task automatic t_response();
        int s;
        s_tx = 48'h7713_0102_0300;
        @(negedge clk) cmd_in = 1'b1;
        expect_frame("R4 switch", 16'h0400);
        @(negedge clk) begin resp_valid = 1'b1; resp_chan = 8'h09; resp_data = 8'h99; end
        @(negedge clk) resp_valid = 1'b0;
        expect_quiet("R7 resp ignored early", 40);
        ack_pulse();
        s = frames;
        wait_frame("R5 pull frame", s);
        ack_pulse();
        chk(cv_frame == 48'h7713_0102_0300, "R6 frame", cv_frame, 48'h7713_0102_0300);
        expect_quiet("R7 waits for response", 40);
        @(negedge clk) begin resp_valid = 1'b1; resp_chan = 8'h05; resp_data = 8'h77; end
        @(negedge clk) resp_valid = 1'b0;
        expect_frame("R7 response packet", 16'h0577);
        push(8'h03, 8'h44);
        expect_quiet("R7 wait after response", 40);
        ack_pulse();
        expect_frame("R7 released", 16'h0344);
        ack_pulse();
        @(negedge clk) cmd_in = 1'b0;
        tick(4);
    endtask

    task automatic t_timeout();
        push(8'h01, 8'h55);
        expect_frame("R1 packet", 16'h0155);
        push(8'h02, 8'h56);
        expect_quiet("R8 before expiry", 120);
        expect_frame("R8 expiry ack high", 16'h0256);
        @(negedge clk) ack_in = 1'b0;
        tick(260);
        push(8'h03, 8'h57);
        expect_quiet("R8 expiry ack low", 200);
        @(negedge clk) ack_in = 1'b1;
        expect_frame("R8 R3 off then edge", 16'h0357);
        ack_pulse();
    endtask

    task automatic t_overflow();
        push(8'h01, 8'h60);
        expect_frame("R1 packet", 16'h0160);
        for (int i = 1; i <= QD; i++) push(8'h01, 8'(8'h60 + i));
        chk(overflow == 1'b0, "R9 full no flag", overflow, 0);
        push(8'h01, 8'h6F);
        chk(overflow == 1'b1, "R9 drop sets flag", overflow, 1);
        for (int i = 1; i <= QD; i++) begin
            ack_pulse();
            expect_frame("R9 R1 drain order", {8'h01, 8'(8'h60 + i)});
        end
        ack_pulse();
        expect_quiet("R9 dropped entry absent", 60);
        chk(overflow == 1'b1, "R9 flag sticky", overflow, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset_low();
        t_wait_gating();
        t_cmd_ignored();
        t_switch_pull();
        t_response();
        t_timeout();
        t_overflow();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
    end
endmodule